// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Load Stall Unit

This block sits in the decode stage of a five-stage in-order integer pipeline. It chooses the two source operands that go to the execute stage. Each operand comes from one of two places. The first is the register file read data. The second is a newer in-flight result held by a later stage: the execute output, the memory-access output, or the value entering writeback. The writeback bypass is needed because the register file keeps returning the old contents of a register until its write has taken effect.

A source can match a stage whose value is a load that has not yet been read from memory. In that case no usable value exists, so the block stalls. It lowers its ready flag, which freezes the program counter and every earlier stage. It also lowers its valid flag, so the execute stage receives a bubble. The stall ends in the cycle the load data appears at the memory-access output, and in that cycle the value is forwarded from there. The chosen operands and the valid flag are captured in an issue register that feeds the execute stage. That register advances whenever the execute stage is ready.

Top module: `fwd_stall_unit`

## Requirements
- R1: After reset, `iss_valid` is 0 and `iss_op1`/`iss_op2` are 0.
- R2: A source with no valid, register-writing later stage holding the same nonzero index takes the register file data (`rf_rdata1` for source 1, `rf_rdata2` for source 2).
- R3: A source matching the execute stage (valid, writes a register, same index, no load waiting) takes `ex_result`.
- R4: A source matching the memory-access stage (valid, writes, same index, no load waiting) takes `ma_result`, unless the execute stage also matches.
- R5: A source matching the writeback input (valid, writes, same index) takes `wb_result`, unless a younger stage also matches.
- R6: When several stages match, the youngest wins: execute, then memory-access, then writeback.
- R7: Source index 0 always yields 0 and is never forwarded. A stage whose valid or write-enable flag is low is never a candidate.
- R8: While `id_valid` is 1 and the youngest matching stage of either source has its load-waiting flag at 1, the block drives `dec_ready`=0, `dec_valid`=0 and `pc_hold`=1. On the next edge it places a bubble (`iss_valid`=0) into execute if `ex_ready` is 1.
- R9: A load-use pair costs exactly one bubble. When the load reaches the memory-access output with its waiting flag at 0, the stall releases and `ma_result` is issued.
- R10: While `ex_ready` is 0, `dec_ready` is 0 and `pc_hold` is 1, and the issue register keeps its contents.
- R11: With `ex_ready` at 1, the issue register captures `dec_valid` (which equals `id_valid` when there is no stall) and both selected operands one clock edge after they are presented. An empty decode slot (`id_valid`=0) never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Decode holds an instruction |
| id_rs1 | input | RIDX_W | Source 1 register index |
| id_rs2 | input | RIDX_W | Source 2 register index |
| rf_rdata1 | input | XLEN | Register file data for source 1 |
| rf_rdata2 | input | XLEN | Register file data for source 2 |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load_wait | input | 1 | Execute value is a load not yet read |
| ex_rd | input | RIDX_W | Execute destination index |
| ex_result | input | XLEN | Execute output value |
| ma_valid | input | 1 | Memory-access stage holds a live instruction |
| ma_wen | input | 1 | Memory-access instruction writes a register |
| ma_load_wait | input | 1 | Memory-access value is a load not yet read |
| ma_rd | input | RIDX_W | Memory-access destination index |
| ma_result | input | XLEN | Memory-access output value |
| wb_valid | input | 1 | Writeback input is live |
| wb_wen | input | 1 | Writeback instruction writes a register |
| wb_rd | input | RIDX_W | Writeback destination index |
| wb_result | input | XLEN | Value entering writeback |
| ex_ready | input | 1 | Execute stage accepts a new instruction |
| dec_valid | output | 1 | Decode offers a valid instruction |
| dec_ready | output | 1 | Decode accepts a new instruction |
| pc_hold | output | 1 | Freeze PC and fetch |
| iss_valid | output | 1 | Issue register valid, to execute |
| iss_op1 | output | XLEN | Issued operand 1 |
| iss_op2 | output | XLEN | Issued operand 2 |

## Verification
`dec_valid`, `dec_ready` and `pc_hold` are combinational and settle in the same cycle as the inputs. The bench therefore samples them one nanosecond after driving each vector and before the next edge. `iss_valid`, `iss_op1` and `iss_op2` are due exactly one rising edge later. They are checked one nanosecond after that edge, against values the bench predicted from the inputs of the previous cycle. The load-use sequence is checked cycle by cycle: one bubble edge, then the forwarded load value on the following edge.

// File: rtl/fwd_pkg.sv
// Shared definitions for the decode bypass unit.
// Assumes source order: index 0 is the youngest stage (execute).
package fwd_pkg;
    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_EX = 2'd0,
        SRC_MA = 2'd1,
        SRC_WB = 2'd2
    } fwd_src_e;

    // Per-stage status flags accompanying a destination index and value.
    typedef struct packed {
        logic live;
        logic wr;
        logic ld_wait;
    } stage_flags_t;
endpackage

// File: rtl/fwd_operand_sel.sv
// Chooses one operand from the register file or from the youngest matching
// later stage. Also reports whether that youngest match is an unread load.
// Assumes slot 0 of the arrays is the youngest stage.
module fwd_operand_sel
    import fwd_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5,
    parameter int NSRC   = NUM_SRC
) (
    input  logic [RIDX_W-1:0] src_idx,
    input  logic [XLEN-1:0]   rf_data,
    input  stage_flags_t      st_flags [NSRC],
    input  logic [RIDX_W-1:0] st_rd    [NSRC],
    input  logic [XLEN-1:0]   st_data  [NSRC],
    output logic [XLEN-1:0]   value,
    output logic              need_wait
);
    logic [NSRC-1:0] cand;

    // Candidate flags: live, register-writing, same nonzero index.
    for (genvar g = 0; g < NSRC; g++) begin : g_cand
        assign cand[g] = st_flags[g].live && st_flags[g].wr &&
                         (st_rd[g] == src_idx) && (src_idx != '0);
    end

    // Priority pick: scan oldest to youngest so the youngest overrides.
    always_comb begin
        value     = rf_data;
        need_wait = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                value     = st_data[i];
                need_wait = st_flags[i].ld_wait;
            end
        end
        if (src_idx == '0) begin
            value     = '0;
            need_wait = 1'b0;
        end
    end
endmodule

// File: rtl/fwd_issue_reg.sv
// Decode-to-execute register. It loads whenever the downstream stage
// advances and holds otherwise. Assumes a synchronous active-low reset.
module fwd_issue_reg #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    input  logic            in_valid,
    input  logic [XLEN-1:0] in_op1,
    input  logic [XLEN-1:0] in_op2,
    output logic            out_valid,
    output logic [XLEN-1:0] out_op1,
    output logic [XLEN-1:0] out_op2
);
    // Capture the decode payload when execute accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_op1   <= '0;
            out_op2   <= '0;
        end else if (advance) begin
            out_valid <= in_valid;
            out_op1   <= in_op1;
            out_op2   <= in_op2;
        end
    end
endmodule

// File: rtl/fwd_stall_unit.sv
// Top of the decode bypass and load stall logic. Two operand selectors
// share the three later-stage sources. A load-use hazard or execute
// back-pressure drops ready and holds the PC; a hazard also drops valid.
// Assumes the writeback input never carries an unread load.
module fwd_stall_unit
    import fwd_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [RIDX_W-1:0] id_rs1,
    input  logic [RIDX_W-1:0] id_rs2,
    input  logic [XLEN-1:0]   rf_rdata1,
    input  logic [XLEN-1:0]   rf_rdata2,
    input  logic              ex_valid,
    input  logic              ex_wen,
    input  logic              ex_load_wait,
    input  logic [RIDX_W-1:0] ex_rd,
    input  logic [XLEN-1:0]   ex_result,
    input  logic              ma_valid,
    input  logic              ma_wen,
    input  logic              ma_load_wait,
    input  logic [RIDX_W-1:0] ma_rd,
    input  logic [XLEN-1:0]   ma_result,
    input  logic              wb_valid,
    input  logic              wb_wen,
    input  logic [RIDX_W-1:0] wb_rd,
    input  logic [XLEN-1:0]   wb_result,
    input  logic              ex_ready,
    output logic              dec_valid,
    output logic              dec_ready,
    output logic              pc_hold,
    output logic              iss_valid,
    output logic [XLEN-1:0]   iss_op1,
    output logic [XLEN-1:0]   iss_op2
);
    localparam int NOPS = 2;

    stage_flags_t      flags [NUM_SRC];
    logic [RIDX_W-1:0] rds   [NUM_SRC];
    logic [XLEN-1:0]   datas [NUM_SRC];

    logic [RIDX_W-1:0] op_idx [NOPS];
    logic [XLEN-1:0]   op_rf  [NOPS];
    logic [XLEN-1:0]   op_val [NOPS];
    logic [NOPS-1:0]   op_wait;
    logic              hazard;

    // Gather later-stage status in youngest-first order.
    always_comb begin
        flags[SRC_EX] = '{live: ex_valid, wr: ex_wen, ld_wait: ex_load_wait};
        flags[SRC_MA] = '{live: ma_valid, wr: ma_wen, ld_wait: ma_load_wait};
        flags[SRC_WB] = '{live: wb_valid, wr: wb_wen, ld_wait: 1'b0};
        rds[SRC_EX]   = ex_rd;
        rds[SRC_MA]   = ma_rd;
        rds[SRC_WB]   = wb_rd;
        datas[SRC_EX] = ex_result;
        datas[SRC_MA] = ma_result;
        datas[SRC_WB] = wb_result;
    end

    assign op_idx[0] = id_rs1;
    assign op_idx[1] = id_rs2;
    assign op_rf[0]  = rf_rdata1;
    assign op_rf[1]  = rf_rdata2;

    for (genvar k = 0; k < NOPS; k++) begin : g_op
        fwd_operand_sel #(
            .XLEN  (XLEN),
            .RIDX_W(RIDX_W),
            .NSRC  (NUM_SRC)
        ) u_sel (
            .src_idx  (op_idx[k]),
            .rf_data  (op_rf[k]),
            .st_flags (flags),
            .st_rd    (rds),
            .st_data  (datas),
            .value    (op_val[k]),
            .need_wait(op_wait[k])
        );
    end

    // Stall decision and handshake outputs.
    always_comb begin
        hazard    = id_valid && (op_wait != '0);
        dec_valid = id_valid && !hazard;
        dec_ready = ex_ready && !hazard;
        pc_hold   = !dec_ready;
    end

    fwd_issue_reg #(.XLEN(XLEN)) u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (ex_ready),
        .in_valid (dec_valid),
        .in_op1   (op_val[0]),
        .in_op2   (op_val[1]),
        .out_valid(iss_valid),
        .out_op1  (iss_op1),
        .out_op2  (iss_op2)
    );
endmodule

// File: rtl/fwd_stall_unit_chk.sv
// Temporal checks on the bypass unit, attached through bind.
module fwd_stall_unit_chk #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              id_valid,
    input logic [RIDX_W-1:0] id_rs1,
    input logic              ex_valid,
    input logic              ex_wen,
    input logic              ex_load_wait,
    input logic [RIDX_W-1:0] ex_rd,
    input logic [XLEN-1:0]   ex_result,
    input logic              ex_ready,
    input logic              dec_valid,
    input logic              dec_ready,
    input logic              pc_hold,
    input logic              iss_valid,
    input logic [XLEN-1:0]   iss_op1,
    input logic [XLEN-1:0]   iss_op2
);
    // Stall toward an accepting execute stage leaves a bubble.
    assert_bubble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_ready && !dec_ready) |=> !iss_valid);

    // A youngest match on an unread load must stall.
    assert_load_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && ex_valid && ex_wen && ex_load_wait &&
         ex_rd == id_rs1 && id_rs1 != '0) |-> (!dec_ready && !dec_valid && pc_hold));

    // Back-pressure holds the issue register.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_ready |=> ($stable(iss_valid) && $stable(iss_op1) && $stable(iss_op2)));

    // Back-pressure drops ready.
    assert_bp_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_ready |-> (!dec_ready && pc_hold));

    // Index zero is issued as zero.
    assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_ready && id_rs1 == '0) |=> (iss_op1 == '0));

    // Execute-stage match wins and is issued next cycle.
    assert_ex_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_ready && ex_valid && ex_wen && !ex_load_wait &&
         ex_rd == id_rs1 && id_rs1 != '0) |=> (iss_op1 == $past(ex_result)));

    // Empty decode slot never stalls.
    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_valid && ex_ready) |-> (dec_ready && !dec_valid));
endmodule

bind fwd_stall_unit fwd_stall_unit_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (.*);

// File: tb/sim_fwd_stall_unit.sv
module sim_fwd_stall_unit;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              id_valid = 1'b0;
    logic [RIDX_W-1:0] id_rs1 = '0, id_rs2 = '0;
    logic [XLEN-1:0]   rf_rdata1 = '0, rf_rdata2 = '0;
    logic              ex_valid = 1'b0, ex_wen = 1'b0, ex_load_wait = 1'b0;
    logic [RIDX_W-1:0] ex_rd = '0;
    logic [XLEN-1:0]   ex_result = '0;
    logic              ma_valid = 1'b0, ma_wen = 1'b0, ma_load_wait = 1'b0;
    logic [RIDX_W-1:0] ma_rd = '0;
    logic [XLEN-1:0]   ma_result = '0;
    logic              wb_valid = 1'b0, wb_wen = 1'b0;
    logic [RIDX_W-1:0] wb_rd = '0;
    logic [XLEN-1:0]   wb_result = '0;
    logic              ex_ready = 1'b1;
    logic              dec_valid, dec_ready, pc_hold, iss_valid;
    logic [XLEN-1:0]   iss_op1, iss_op2;

    int compared = 0;
    int mismatched = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    fwd_stall_unit #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u0 (.*);

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference pick: {wait, value} for one source index.
    function automatic logic [XLEN:0] model(input logic [RIDX_W-1:0] idx,
                                            input logic [XLEN-1:0] rf);
        if (idx == '0) return '0;
        if (ex_valid && ex_wen && ex_rd == idx) return {ex_load_wait, ex_result};
        if (ma_valid && ma_wen && ma_rd == idx) return {ma_load_wait, ma_result};
        if (wb_valid && wb_wen && wb_rd == idx) return {1'b0, wb_result};
        return {1'b0, rf};
    endfunction

    // Check combinational outputs now, registered outputs after the next edge.
    task automatic step(input string req);
        logic [XLEN:0] m1, m2;
        logic haz, e_valid, e_ready;
        #1;
        m1 = model(id_rs1, rf_rdata1);
        m2 = model(id_rs2, rf_rdata2);
        haz = id_valid && (m1[XLEN] || m2[XLEN]);
        e_valid = id_valid && !haz;
        e_ready = ex_ready && !haz;
        check({req, " dec_valid"}, XLEN'(dec_valid), XLEN'(e_valid));
        check({req, " dec_ready"}, XLEN'(dec_ready), XLEN'(e_ready));
        check({req, " pc_hold"}, XLEN'(pc_hold), XLEN'(!e_ready));
        if (ex_ready) begin
            @(posedge clk);
            #1;
            check({req, " iss_valid"}, XLEN'(iss_valid), XLEN'(e_valid));
            check({req, " iss_op1"}, iss_op1, m1[XLEN-1:0]);
            check({req, " iss_op2"}, iss_op2, m2[XLEN-1:0]);
        end else begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic clear_stages();
        ex_valid = 0; ex_wen = 0; ex_load_wait = 0; ex_rd = '0;
        ma_valid = 0; ma_wen = 0; ma_load_wait = 0; ma_rd = '0;
        wb_valid = 0; wb_wen = 0; wb_rd = '0;
    endtask

    initial begin
        logic v0; logic [XLEN-1:0] o1, o2;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 iss_valid", XLEN'(iss_valid), '0);
        check("R1 iss_op1", iss_op1, '0);
        check("R1 iss_op2", iss_op2, '0);
        rst_n = 1'b1;

        // Sweep over indices 0..3 and stage flags (R2..R8, R11)
        for (int s1 = 0; s1 < 4; s1++)
        for (int er = 0; er < 4; er++)
        for (int mr = 0; mr < 4; mr++)
        for (int wr = 0; wr < 4; wr++)
        for (int f = 0; f < 64; f++) begin
            int n;
            n = ((s1 * 64 + er * 16 + mr * 4 + wr) * 64) + f;
            id_valid = (n % 7) != 0;
            id_rs1 = RIDX_W'(s1);
            id_rs2 = RIDX_W'((s1 + mr + f) % 4);
            rf_rdata1 = 32'hA100_0000 + n;
            rf_rdata2 = 32'hA200_0000 + n;
            ex_valid = f[0]; ex_wen = f[1]; ex_load_wait = f[2];
            ex_rd = RIDX_W'(er); ex_result = 32'hE000_0000 + n;
            ma_valid = f[3]; ma_wen = f[4]; ma_load_wait = f[5];
            ma_rd = RIDX_W'(mr); ma_result = 32'hD000_0000 + n;
            wb_valid = (s1 % 2 == 1) || f[2];
            wb_wen = !f[5] || (er % 2 == 1);
            wb_rd = RIDX_W'(wr); wb_result = 32'hB000_0000 + n;
            ex_ready = 1'b1;
            step("R2-sweep R3 R4 R5 R6 R7 R8 R11");
        end

        // R3: back-to-back dependent ALU ops
        clear_stages(); id_valid = 1; id_rs1 = 5'd7; id_rs2 = 5'd7;
        ex_valid = 1; ex_wen = 1; ex_rd = 5'd7; ex_result = 32'h1111_0001;
        ma_valid = 1; ma_wen = 1; ma_rd = 5'd7; ma_result = 32'h2222_0002;
        step("R3 back-to-back");
        check("R6 youngest op1", iss_op1, 32'h1111_0001);

        // R4: distance two
        clear_stages(); ma_valid = 1; ma_wen = 1; ma_rd = 5'd9; ma_result = 32'h3333_0003;
        id_rs1 = 5'd9; id_rs2 = 5'd1; rf_rdata2 = 32'h0000_00F2;
        step("R4 distance two");
        check("R4 op1", iss_op1, 32'h3333_0003);

        // R5: distance three
        clear_stages(); wb_valid = 1; wb_wen = 1; wb_rd = 5'd1; wb_result = 32'h4444_0004;
        step("R5 distance three");
        check("R5 op2", iss_op2, 32'h4444_0004);

        // R7: write to x0 never forwarded
        clear_stages(); id_rs1 = 5'd0; id_rs2 = 5'd0;
        ex_valid = 1; ex_wen = 1; ex_rd = 5'd0; ex_result = 32'hDEAD_BEEF;
        rf_rdata1 = 32'h1234_5678; rf_rdata2 = 32'h1234_5678;
        step("R7 x0");
        check("R7 op1 zero", iss_op1, '0);

        // R8/R9: load followed by use, exactly one bubble
        clear_stages(); id_rs1 = 5'd4; id_rs2 = 5'd3; rf_rdata1 = 32'h0BAD_0BAD;
        ex_valid = 1; ex_wen = 1; ex_load_wait = 1; ex_rd = 5'd4; ex_result = 32'h0;
        #1;
        check("R8 stall ready", XLEN'(dec_ready), '0);
        check("R8 stall valid", XLEN'(dec_valid), '0);
        check("R8 pc_hold", XLEN'(pc_hold), 1);
        @(posedge clk); #1;
        check("R8 bubble", XLEN'(iss_valid), '0);
        clear_stages(); ma_valid = 1; ma_wen = 1; ma_rd = 5'd4; ma_result = 32'h5555_0005;
        #1;
        check("R9 release", XLEN'(dec_ready), 1);
        @(posedge clk); #1;
        check("R9 issued valid", XLEN'(iss_valid), 1);
        check("R9 load value", iss_op1, 32'h5555_0005);

        // R8: load still waiting in memory-access stage also stalls
        ma_load_wait = 1;
        step("R8 mem wait");

        // R10: back-pressure holds issue register
        clear_stages(); id_rs1 = 5'd2; rf_rdata1 = 32'h6666_0006; ex_ready = 1;
        step("R11 preload");
        v0 = iss_valid; o1 = iss_op1; o2 = iss_op2;
        ex_ready = 0; rf_rdata1 = 32'h7777_0007;
        step("R10 back-pressure");
        check("R10 hold valid", XLEN'(iss_valid), XLEN'(v0));
        check("R10 hold op1", iss_op1, o1);
        check("R10 hold op2", iss_op2, o2);
        ex_ready = 1;
        step("R11 resume");
        check("R11 op1 after resume", iss_op1, 32'h7777_0007);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule